// File: doc/BRIEF.md
# Serial-In Parallel-Out Word FIFO

This block takes a one-bit serial stream, gathers the bits into words, and queues the finished words in a small storage array. A consumer pulls words back out in the order they were completed, and each word comes out whole on a parallel bus. A word that is still being shifted in cannot be seen by the consumer. The storage array has one write port and one read port, and both can be used in the same cycle. It is written so that an FPGA flow can map it onto block RAM.

The producer offers a bit by raising `serial_valid`. The bit is taken on a clock edge where `serial_ready` is also high. Bits arrive most significant first. On the edge that takes the last bit of a word, the finished word is written straight into the next free slot. While every slot holds an unread word, `serial_ready` stays low and no further bit is taken, not even into a partly built word. The consumer pulses `rd_req`. If the queue has a word, the oldest one appears on `rd_data` one cycle later, marked by a one-cycle `rd_valid`, and its slot becomes free.

Top module: `sipo_word_fifo`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `full` is 0, `serial_ready` is 1 and `rd_valid` is 0, and no partial word remains.
- R2: Bits are packed most significant first. The first bit taken for a word ends up in bit WORD_W-1 (bit 31), and the last bit taken ends up in bit 0.
- R3: A word becomes readable only once all WORD_W bits have been taken. `empty` falls on the edge after the last bit is taken. With fewer bits taken, `empty` stays high.
- R4: Words are returned in exactly the order in which they were completed.
- R5: When DEPTH (64) words are stored and unread, `full` is 1 and `serial_ready` is 0. A bit offered with `serial_valid` high while `serial_ready` is low is not taken and does not change any stored or partial word.
- R6: A `rd_req` while `empty` is 1 is ignored. No `rd_valid` follows, and the read position does not move.
- R7: An accepted read (`rd_req` high while `empty` is 0) produces `rd_valid` high for exactly the following cycle, with the word on `rd_data` in that cycle.
- R8: Reading from a full queue frees a slot. `full` drops and `serial_ready` rises on the next edge, and serial input resumes into the freed slot.
- R9: A word completed in the same cycle as an accepted read leaves the occupancy unchanged. `empty` and `full` always reflect the number of completed words minus the number of accepted reads.
- R10: Cycles with `serial_valid` low take no bit. Gaps inside a word do not change the assembled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serial_valid | input | 1 | Serial bit offered |
| serial_data | input | 1 | Serial bit value, most significant first |
| serial_ready | output | 1 | Block will take a bit this cycle |
| rd_req | input | 1 | Request to pop the oldest word |
| rd_valid | output | 1 | `rd_data` holds a popped word this cycle |
| rd_data | output | WORD_W | Popped word |
| empty | output | 1 | No completed word stored |
| full | output | 1 | All DEPTH slots hold unread words |

## Verification
A single word sent with random gaps in `serial_valid`, and holding a marker pattern with both end bits set, separates correct most-significant-first packing from a reversed or shifted packing. It also shows that gaps do not disturb the word. A long fill to capacity, with bits still offered afterwards, separates a correct refusal from one that takes bits into the partial word or overwrites the oldest slot. Draining with reads issued back to back exposes any error in word order or in where the pointers wrap. A mixed phase runs serial input and random reads at the same time, including requests against an empty queue and against a full one, and so tests same-cycle read and commit as well as reads that are correctly ignored.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_DEPTH  = 64;
endpackage

// File: rtl/sipo_bit_assembler.sv
module sipo_bit_assembler #(
  parameter int unsigned WORD_W = sipo_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              bit_in,
  output logic              word_done,
  output logic [WORD_W-1:0] word_out
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] shift_q;

  // the completed word includes the bit arriving this cycle
  assign word_done = take && (cnt_q == LAST);
  assign word_out  = {shift_q, bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (take) begin
      shift_q <= {shift_q[WORD_W-3:0], bit_in};
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sipo_ptr_ctrl.sv
module sipo_ptr_ctrl #(
  parameter int unsigned DEPTH = sipo_pkg::DEF_DEPTH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic                     pop,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     empty,
  output logic                     full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wr_q, rd_q, wr_n, rd_n;

  always_comb begin
    wr_n = push ? wr_q + PW'(1) : wr_q;
    rd_n = pop  ? rd_q + PW'(1) : rd_q;
  end

  assign wr_addr = wr_q[AW-1:0];
  assign rd_addr = rd_q[AW-1:0];

  // flags registered from next-state pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      empty <= (wr_n == rd_n);
      full  <= (wr_n[AW] != rd_n[AW]) && (wr_n[AW-1:0] == rd_n[AW-1:0]);
    end
  end
endmodule

// File: rtl/sipo_sdp_ram.sv
module sipo_sdp_ram #(
  parameter int unsigned WIDTH = sipo_pkg::DEF_WORD_W,
  parameter int unsigned DEPTH = sipo_pkg::DEF_DEPTH
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sipo_word_fifo.sv
module sipo_word_fifo #(
  parameter int unsigned WORD_W = sipo_pkg::DEF_WORD_W,
  parameter int unsigned DEPTH  = sipo_pkg::DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_valid,
  input  logic              serial_data,
  output logic              serial_ready,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic              take, word_done, pop;
  logic [WORD_W-1:0] word;
  logic [AW-1:0]     wr_addr, rd_addr;

  assign serial_ready = !full;
  assign take         = serial_valid && serial_ready;
  assign pop          = rd_req && !empty;

  sipo_bit_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst(rst), .take(take), .bit_in(serial_data),
    .word_done(word_done), .word_out(word)
  );

  sipo_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .push(word_done), .pop(pop),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .empty(empty), .full(full)
  );

  sipo_sdp_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(word_done), .waddr(wr_addr), .wdata(word),
    .re(pop), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= pop;
  end
endmodule

// File: rtl/sipo_word_fifo_chk.sv
module sipo_word_fifo_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 64
) (
  input logic clk,
  input logic rst,
  input logic serial_valid,
  input logic serial_ready,
  input logic rd_req,
  input logic rd_valid,
  input logic empty,
  input logic full
);
  int  bits_seen;
  int  occ;
  logic commit, popped;

  assign commit = serial_valid && serial_ready && (bits_seen == int'(WORD_W) - 1);
  assign popped = rd_req && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_seen <= 0;
      occ       <= 0;
    end else begin
      if (serial_valid && serial_ready)
        bits_seen <= (bits_seen == int'(WORD_W) - 1) ? 0 : bits_seen + 1;
      occ <= occ + (commit ? 1 : 0) - (popped ? 1 : 0);
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full && serial_ready && !rd_valid)); // R1
  AST_EMPTY_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    $fell(empty) |-> $past(commit)); // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    full |-> !serial_ready); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R5
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> !rd_valid); // R6
  AST_RDVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req && !empty)); // R7
  AST_OCC_EMPTY: assert property (@(posedge clk) disable iff (rst)
    empty == (occ == 0)); // R9
  AST_OCC_FULL: assert property (@(posedge clk) disable iff (rst)
    full == (occ == int'(DEPTH))); // R9
endmodule

bind sipo_word_fifo sipo_word_fifo_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .serial_valid(serial_valid), .serial_ready(serial_ready),
  .rd_req(rd_req), .rd_valid(rd_valid), .empty(empty), .full(full)
);

// File: tb/sim_sipo_word_fifo.sv
module sim_sipo_word_fifo;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DEPTH  = 64;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_valid = 1'b0, serial_data = 1'b0, rd_req = 1'b0;
  logic serial_ready, rd_valid, empty, full;
  logic [WORD_W-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 1'b0;
  bit done     = 1'b0;

  // behavioural reference
  logic [WORD_W-1:0] q[$];
  logic [WORD_W-1:0] m_shift;
  int   m_cnt;
  bit   m_rv;
  logic [WORD_W-1:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sipo_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .serial_valid(serial_valid), .serial_data(serial_data),
    .serial_ready(serial_ready), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .empty(empty), .full(full)
  );

  task automatic check(input bit ok, input string tag, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_cnt = 0; m_shift = '0; m_rv = 1'b0;
    end else begin
      bit ready_m;
      ready_m = (q.size() != DEPTH);
      m_rv = 1'b0;
      if (rd_req && q.size() != 0) begin
        m_data = q.pop_front();
        m_rv = 1'b1;
      end
      if (serial_valid && ready_m) begin
        m_shift = {m_shift[WORD_W-2:0], serial_data};
        m_cnt++;
        if (m_cnt == WORD_W) begin
          q.push_back(m_shift);
          m_cnt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(empty == (q.size() == 0), "R3/R9 empty", WORD_W'(empty), WORD_W'(q.size() == 0));
      check(full == (q.size() == DEPTH), "R5/R8 full", WORD_W'(full), WORD_W'(q.size() == DEPTH));
      check(serial_ready == (q.size() != DEPTH), "R5 serial_ready",
            WORD_W'(serial_ready), WORD_W'(q.size() != DEPTH));
      check(rd_valid == m_rv, "R6/R7 rd_valid", WORD_W'(rd_valid), WORD_W'(m_rv));
      if (m_rv) check(rd_data == m_data, "R4/R7 rd_data", rd_data, m_data);
    end
  end

  task automatic send_word(input logic [WORD_W-1:0] w, input bit gaps);
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (gaps) begin
        while ($urandom_range(0, 2) == 0) begin
          @(negedge clk); serial_valid = 1'b0; serial_data = $urandom_range(0, 1); // R10
        end
      end
      @(negedge clk);
      serial_valid = 1'b1; serial_data = w[i];
      while (!serial_ready) @(negedge clk);
    end
    @(negedge clk); serial_valid = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(empty && !full && serial_ready && !rd_valid, "R1 reset flags",
          {28'd0, empty, full, serial_ready, rd_valid}, 32'hA);
    cmp_on = 1'b1;

    // R6 read on empty
    pulse_read();
    check(!rd_valid, "R6 no rd_valid after empty read", WORD_W'(rd_valid), '0);

    // R2 / R10 marker word with gaps; R3 partial not visible
    for (int i = 0; i < 31; i++) begin
      @(negedge clk); serial_valid = 1'b1; serial_data = (i == 0);
    end
    @(negedge clk); serial_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(empty, "R3 partial word hidden", WORD_W'(empty), 1);
    @(negedge clk); serial_valid = 1'b1; serial_data = 1'b1;
    @(negedge clk); serial_valid = 1'b0;
    check(!empty, "R3 word visible after last bit", WORD_W'(empty), 0);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check(rd_valid && rd_data == 32'h8000_0001, "R2 msb-first packing", rd_data, 32'h8000_0001);
    @(negedge clk);
    check(!rd_valid, "R7 rd_valid single cycle", WORD_W'(rd_valid), 0);

    send_word(32'hC3A5_0F1E, 1'b1);
    pulse_read();
    check(rd_data == 32'hC3A5_0F1E, "R10 gaps keep word", rd_data, 32'hC3A5_0F1E);

    // R5 fill to capacity, then keep offering bits
    for (int k = 0; k < DEPTH; k++) send_word(32'hA5A5_A5A5 ^ (k * 32'h0101_0101), 1'b0);
    check(full && !serial_ready, "R5 full after DEPTH words", {30'd0, full, serial_ready}, 32'h2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); serial_valid = 1'b1; serial_data = i[0];
    end
    check(full, "R5 bits refused while full", WORD_W'(full), 1);

    // R8 read while full with input pending
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check(!full && serial_ready, "R8 slot freed", {30'd0, full, serial_ready}, 32'h1);
    repeat (40) @(negedge clk);
    serial_valid = 1'b0;

    // R4 drain back to back
    @(negedge clk); rd_req = 1'b1;
    while (!empty) @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
    check(empty, "R4 drained", WORD_W'(empty), 1);

    // R9 mixed traffic
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      serial_valid = ($urandom_range(0, 3) != 0);
      serial_data  = $urandom_range(0, 1);
      rd_req       = ($urandom_range(0, 40) == 0);
    end
    serial_valid = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule